// File: doc/BRIEF.md
# Dual-Port MDIO Management Slave

This block is a management-bus slave for a device that carries two independent channels. It listens to a serial management frame on a single data line, clocked by the management clock, and exposes one small register set per channel. A four-bit strap input fixes the upper part of the bus address. Each device therefore answers on two neighbouring PHY addresses. The least significant address bit picks the channel.

Every frame starts with a run of ones, then a start pattern, an opcode, a five-bit PHY address and a five-bit register number. A two-bit turnaround follows, and then sixteen data bits, most significant first. On a read the slave drives the data line through an output enable. On a write it latches the data into the addressed control register. Each channel has two writable control registers, whose contents also appear on output pins, and two fixed identifier registers. All other register numbers read as zero and ignore writes. The device runs on the reset values of its control registers if the bus is never used.

Top module: `mdio_dual_port_slave`

## Requirements
- R1: A frame is accepted only if at least 32 consecutive ones are sampled just before the start pattern 0 then 1. With 31 or fewer ones, the frame is ignored.
- R2: The slave acts on a frame only when PHY address bits [4:1] equal `strapAddr`. On a mismatch `mdioOe` stays low for the whole frame and no register changes.
- R3: PHY address bit 0 = 0 addresses channel A and bit 0 = 1 addresses channel B. An access to one channel never alters the other channel's registers.
- R4: A write (opcode bits 0 then 1) to register 0 or 1 loads the sixteen data bits into that channel's control register. Register r of channel A appears on `ctrlA[16*r+15:16*r]`, and channel B likewise on `ctrlB`. A later read returns the written value.
- R5: A write to register 2 or 3 (read-only) or to registers 4 to 31 (not implemented) changes no state.
- R6: A read of registers 4 to 31 returns 16'h0000.
- R7: On both channels, register 2 reads as `ID_WORD2` (default 16'h2A5C) and register 3 reads as `ID_WORD3` (default 16'h41E0).
- R8: On an accepted read (opcode bits 1 then 0), the slave keeps `mdioOe` low in the first turnaround bit and drives 0 in the second. It then drives data bits 15 down to 0 and releases the line in the bit after bit 0. Every output change follows a rising edge of `mdc`.
- R9: While `rst` is high at a rising edge of `mdc`, both control registers of both channels become 0, `mdioOe` goes low, and the slave returns to searching for a preamble.
- R10: Frames with opcode 00 or 11 are ignored: the line is not driven and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strapAddr | input | 4 | Strap value compared with PHY address bits [4:1] |
| mdioIn | input | 1 | Sampled level of the management data line |
| mdioOut | output | 1 | Value driven onto the data line when enabled |
| mdioOe | output | 1 | Output enable for the data line driver |
| ctrlA | output | CTRL_REGS*16 (32) | Channel A control registers, register r in bits [16r+15:16r] |
| ctrlB | output | CTRL_REGS*16 (32) | Channel B control registers, same layout |

## Verification
On every cycle, the assertions check these points. The controller leaves preamble search only after a full run of ones. It proceeds past the header only when the address matches the strap and the opcode is legal. The driver's first enabled bit is the turnaround zero, the line is released after the last data bit, and an unimplemented read puts a zero on the line. Control registers stay stable unless a write commit addresses them, and a write to one channel never disturbs the other. The data values themselves can only be shown by the bench's scenarios: the identifier contents, that writes read back, that writes to read-only and missing registers have no effect, the exact preamble boundary at 31 and 32 ones, and the ignored opcodes. The bench observes each of these at the data line and on the control outputs.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  localparam int WORD_W   = 16;
  localparam int HDR_BITS = 12;  // opcode, PHY address, register address
  localparam int HDR_KEEP = 11;  // bits retained: opcode LSB, PHY address, register

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_RDATA,
    ST_WDATA
  } mdioState_t;

  typedef struct packed {
    logic hdrShift;
    logic taDrive;
    logic rdLoad;
    logic rdShift;
    logic rdDone;
    logic wrShift;
    logic wrCommit;
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        mdc,
  input  logic        rst,
  input  logic        mdioIn,
  input  logic [3:0]  strapAddr,
  input  logic [5:0]  hdrBits,   // header shift register bits [10:5]
  output mdioStrobe_t strobes
);

  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] PRE_FULL  = CNT_W'(PRE_LEN);
  localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(HDR_BITS - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(WORD_W - 1);

  mdioState_t       state;
  logic [CNT_W-1:0] onesCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             isRead;

  // Header as it will be once the bit now on the line is shifted in.
  logic [1:0] opNext;
  logic [3:0] phyHiNext;
  logic       frameOk;

  assign opNext    = hdrBits[5:4];
  assign phyHiNext = hdrBits[3:0];
  assign frameOk   = (phyHiNext == strapAddr) &&
                     ((opNext == OP_READ) || (opNext == OP_WRITE));

  always_comb begin
    strobes = '0;
    case (state)
      ST_HDR:   strobes.hdrShift = 1'b1;
      ST_TA1:   strobes.taDrive  = isRead;
      ST_TA2:   strobes.rdLoad   = isRead;
      ST_RDATA: begin
        strobes.rdShift = (bitCnt != DATA_LAST);
        strobes.rdDone  = (bitCnt == DATA_LAST);
      end
      ST_WDATA: begin
        strobes.wrShift  = 1'b1;
        strobes.wrCommit = (bitCnt == DATA_LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge mdc) begin
    if (rst) begin
      state   <= ST_HUNT;
      onesCnt <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (mdioIn) begin
            if (onesCnt != PRE_FULL) onesCnt <= onesCnt + 1'b1;
          end else begin
            if (onesCnt == PRE_FULL) state <= ST_START;
            onesCnt <= '0;
          end
        end
        ST_START: begin
          state  <= mdioIn ? ST_HDR : ST_HUNT;
          bitCnt <= '0;
        end
        ST_HDR: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == HDR_LAST) begin
            bitCnt <= '0;
            if (frameOk) begin
              isRead <= (opNext == OP_READ);
              state  <= ST_TA1;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_TA1: state <= ST_TA2;
        ST_TA2: begin
          state  <= isRead ? ST_RDATA : ST_WDATA;
          bitCnt <= '0;
        end
        ST_RDATA, ST_WDATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // The start pattern is only looked for after a full run of ones.
  assert_preamble_R1: assert property (@(posedge mdc) disable iff (rst)
    (state == ST_START) |-> ($past(onesCnt) == PRE_FULL));

  // Past the header, the latched address always matches the strap.
  assert_addr_match_R2: assert property (@(posedge mdc) disable iff (rst)
    (state inside {ST_TA1, ST_TA2, ST_RDATA, ST_WDATA}) |-> (hdrBits[4:1] == strapAddr));

  // A turnaround is entered only for a legal, matching header.
  assert_legal_op_R10: assert property (@(posedge mdc) disable iff (rst)
    (state == ST_TA1) |-> $past(frameOk));

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_slave_pkg::*;
#(
  parameter int          CTRL_REGS = 2,
  parameter logic [15:0] ID_WORD2  = 16'h2A5C,
  parameter logic [15:0] ID_WORD3  = 16'h41E0
) (
  input  logic                          mdc,
  input  logic                          rst,
  input  logic                          mdioIn,
  input  mdioStrobe_t                   strobes,
  output logic [5:0]                    hdrBits,
  output logic                          mdioOut,
  output logic                          mdioOe,
  output logic [CTRL_REGS*WORD_W-1:0]   ctrlA,
  output logic [CTRL_REGS*WORD_W-1:0]   ctrlB
);

  localparam int NUM_CH     = 2;
  localparam int TOTAL_REGS = CTRL_REGS + 2;
  localparam logic [4:0] ID2_ADDR = 5'(CTRL_REGS);
  localparam logic [4:0] ID3_ADDR = 5'(CTRL_REGS + 1);

  logic [HDR_KEEP-1:0] hdrSr;     // [10] opcode LSB, [9:5] PHY address, [4:0] register
  logic [WORD_W-2:0]   wrSr;
  logic [WORD_W-2:0]   rdSr;
  logic [WORD_W-1:0]   wrNext;
  logic [WORD_W-1:0]   rdWord;
  logic                chanSel;
  logic [4:0]          regAddr;
  logic [WORD_W-1:0]   ctrlReg [NUM_CH][CTRL_REGS];

  assign chanSel = hdrSr[5];
  assign regAddr = hdrSr[4:0];
  assign hdrBits = hdrSr[10:5];
  assign wrNext  = {wrSr, mdioIn};

  always_ff @(posedge mdc) begin
    if (rst) hdrSr <= '0;
    else if (strobes.hdrShift) hdrSr <= {hdrSr[HDR_KEEP-2:0], mdioIn};
  end

  always_ff @(posedge mdc) begin
    if (rst) wrSr <= '0;
    else if (strobes.wrShift) wrSr <= {wrSr[WORD_W-3:0], mdioIn};
  end

  always_ff @(posedge mdc) begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int r = 0; r < CTRL_REGS; r++) begin
        if (rst) ctrlReg[ch][r] <= '0;
        else if (strobes.wrCommit && (chanSel == 1'(ch)) && (regAddr == 5'(r)))
          ctrlReg[ch][r] <= wrNext;
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int r = 0; r < CTRL_REGS; r++)
      if (regAddr == 5'(r)) rdWord = ctrlReg[chanSel][r];
    if (regAddr == ID2_ADDR) rdWord = ID_WORD2;
    if (regAddr == ID3_ADDR) rdWord = ID_WORD3;
  end

  always_ff @(posedge mdc) begin
    if (rst) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
      rdSr    <= '0;
    end else if (strobes.taDrive) begin
      mdioOe  <= 1'b1;
      mdioOut <= 1'b0;
    end else if (strobes.rdLoad) begin
      mdioOe  <= 1'b1;
      mdioOut <= rdWord[WORD_W-1];
      rdSr    <= rdWord[WORD_W-2:0];
    end else if (strobes.rdShift) begin
      mdioOut <= rdSr[WORD_W-2];
      rdSr    <= {rdSr[WORD_W-3:0], 1'b0};
    end else if (strobes.rdDone) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
    end
  end

  for (genvar g = 0; g < CTRL_REGS; g++) begin : g_ctrlOut
    assign ctrlA[g*WORD_W +: WORD_W] = ctrlReg[0][g];
    assign ctrlB[g*WORD_W +: WORD_W] = ctrlReg[1][g];
  end

  // The first driven bit of a read is always the turnaround zero.
  assert_ta_zero_R8: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdioOe) |-> !mdioOut);

  // The line is released right after the last data bit.
  assert_release_R8: assert property (@(posedge mdc) disable iff (rst)
    strobes.rdDone |=> !mdioOe);

  // A missing register puts a zero MSB on the line.
  assert_unimpl_read_R6: assert property (@(posedge mdc) disable iff (rst)
    (strobes.rdLoad && (regAddr >= 5'(TOTAL_REGS))) |=> (mdioOe && !mdioOut));

  // Control registers move only on a commit that addresses them.
  assert_ro_guard_R5: assert property (@(posedge mdc) disable iff (rst)
    !(strobes.wrCommit && (regAddr < 5'(CTRL_REGS))) |=> ($stable(ctrlA) && $stable(ctrlB)));

  // A write to one channel leaves the other untouched.
  assert_chan_isolation_R3: assert property (@(posedge mdc) disable iff (rst)
    (strobes.wrCommit && !chanSel) |=> $stable(ctrlB));

  // A commit to channel A register 0 lands the shifted word.
  assert_write_land_R4: assert property (@(posedge mdc) disable iff (rst)
    (strobes.wrCommit && !chanSel && (regAddr == 5'd0)) |=> (ctrlA[WORD_W-1:0] == $past(wrNext)));

endmodule

// File: rtl/mdio_dual_port_slave.sv
module mdio_dual_port_slave
  import mdio_slave_pkg::*;
#(
  parameter int          PRE_LEN   = 32,
  parameter int          CTRL_REGS = 2,
  parameter logic [15:0] ID_WORD2  = 16'h2A5C,
  parameter logic [15:0] ID_WORD3  = 16'h41E0
) (
  input  logic                    mdc,
  input  logic                    rst,
  input  logic [3:0]              strapAddr,
  input  logic                    mdioIn,
  output logic                    mdioOut,
  output logic                    mdioOe,
  output logic [CTRL_REGS*16-1:0] ctrlA,
  output logic [CTRL_REGS*16-1:0] ctrlB
);

  mdioStrobe_t strobes;
  logic [5:0]  hdrBits;

  mdio_frame_ctrl #(
    .PRE_LEN(PRE_LEN)
  ) ctrl_i (
    .mdc      (mdc),
    .rst      (rst),
    .mdioIn   (mdioIn),
    .strapAddr(strapAddr),
    .hdrBits  (hdrBits),
    .strobes  (strobes)
  );

  mdio_reg_bank #(
    .CTRL_REGS(CTRL_REGS),
    .ID_WORD2 (ID_WORD2),
    .ID_WORD3 (ID_WORD3)
  ) bank_i (
    .mdc    (mdc),
    .rst    (rst),
    .mdioIn (mdioIn),
    .strobes(strobes),
    .hdrBits(hdrBits),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe),
    .ctrlA  (ctrlA),
    .ctrlB  (ctrlB)
  );

endmodule

// File: tb/mdio_dual_port_slave_tb.sv
module mdio_dual_port_slave_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam logic [15:0] ID2 = 16'h2A5C;
  localparam logic [15:0] ID3 = 16'h41E0;
  localparam logic [3:0]  STRAP  = 4'b1011;
  localparam logic [4:0]  PHY_A  = {STRAP, 1'b0};
  localparam logic [4:0]  PHY_B  = {STRAP, 1'b1};
  localparam logic [1:0]  RD = 2'b10;
  localparam logic [1:0]  WR = 2'b01;

  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  strapAddr = STRAP;
  logic        mdioIn = 1'b1;
  logic        mdioOut;
  logic        mdioOe;
  logic [31:0] ctrlA;
  logic [31:0] ctrlB;

  int total = 0;
  int bad   = 0;

  mdio_dual_port_slave dut_i (
    .mdc      (mdc),
    .rst      (rst),
    .strapAddr(strapAddr),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .ctrlA    (ctrlA),
    .ctrlB    (ctrlB)
  );

  always #(CLK_PERIOD / 2) mdc = ~mdc;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bit period: sample the slave's value for this bit, then drive ours.
  task automatic bitCycle(input logic b, output logic oeS, output logic outS);
    @(negedge mdc);
    oeS    = mdioOe;
    outS   = mdioOut;
    mdioIn = b;
  endtask

  task automatic sendFrame(input int preLen, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] regA, input logic [15:0] wdata,
                           output logic [15:0] rdata, output int oeSeen, output bit taOk);
    logic oeS, outS;
    logic [13:0] hdr;
    hdr    = {2'b01, op, phy, regA};
    oeSeen = 0;
    taOk   = 1'b1;
    rdata  = '0;
    bitCycle(1'b0, oeS, outS);
    for (int i = 0; i < preLen; i++) begin
      bitCycle(1'b1, oeS, outS);
      oeSeen += (oeS === 1'b1) ? 1 : 0;
    end
    for (int i = 13; i >= 0; i--) begin
      bitCycle(hdr[i], oeS, outS);
      oeSeen += (oeS === 1'b1) ? 1 : 0;
    end
    bitCycle(1'b1, oeS, outS);
    oeSeen += (oeS === 1'b1) ? 1 : 0;
    if (oeS !== 1'b0) taOk = 1'b0;
    bitCycle((op == RD) ? 1'b1 : 1'b0, oeS, outS);
    oeSeen += (oeS === 1'b1) ? 1 : 0;
    if (!(oeS === 1'b1 && outS === 1'b0)) taOk = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      bitCycle((op == RD) ? 1'b1 : wdata[i], oeS, outS);
      oeSeen += (oeS === 1'b1) ? 1 : 0;
      rdata[i] = outS;
      if (oeS !== 1'b1) taOk = 1'b0;
    end
    bitCycle(1'b1, oeS, outS);
    oeSeen += (oeS === 1'b1) ? 1 : 0;
    if (oeS !== 1'b0) taOk = 1'b0;
  endtask

  task automatic doWrite(input int preLen, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] regA, input logic [15:0] wdata, output int oeSeen);
    logic [15:0] rd;
    bit ok;
    sendFrame(preLen, op, phy, regA, wdata, rd, oeSeen, ok);
  endtask

  task automatic doRead(input logic [4:0] phy, input logic [4:0] regA,
                        output logic [15:0] rdata, output bit taOk);
    int seen;
    sendFrame(32, RD, phy, regA, 16'h0000, rdata, seen, taOk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (4) @(negedge mdc);
    rst = 1'b0;
    check("R9", "reset oe", {31'd0, mdioOe}, 32'd0);
    check("R9", "reset ctrlA", ctrlA, 32'd0);
    check("R9", "reset ctrlB", ctrlB, 32'd0);
  endtask

  task automatic testIdRead();
    logic [15:0] d;
    bit ok;
    doRead(PHY_A, 5'd2, d, ok);
    check("R7", "chA reg2 id", {16'd0, d}, {16'd0, ID2});
    check("R8", "read turnaround and release timing", {31'd0, ok}, 32'd1);
    doRead(PHY_B, 5'd3, d, ok);
    check("R7", "chB reg3 id", {16'd0, d}, {16'd0, ID3});
    check("R8", "chB read timing", {31'd0, ok}, 32'd1);
  endtask

  task automatic testWrite();
    logic [15:0] d;
    bit ok;
    int seen;
    doWrite(32, WR, PHY_A, 5'd0, 16'h1234, seen);
    check("R4", "chA reg0 write", ctrlA, 32'h0000_1234);
    check("R3", "chB untouched by chA write", ctrlB, 32'h0);
    check("R4", "write never drives line", seen, 0);
    doWrite(32, WR, PHY_B, 5'd1, 16'hBEEF, seen);
    check("R3", "chB reg1 write", ctrlB, 32'hBEEF_0000);
    check("R3", "chA untouched by chB write", ctrlA, 32'h0000_1234);
    doRead(PHY_B, 5'd1, d, ok);
    check("R4", "chB reg1 readback", {16'd0, d}, 32'h0000_BEEF);
    doRead(PHY_A, 5'd1, d, ok);
    check("R3", "chA reg1 readback", {16'd0, d}, 32'h0);
    doRead(PHY_A, 5'd0, d, ok);
    check("R4", "chA reg0 readback", {16'd0, d}, 32'h0000_1234);
  endtask

  task automatic testReadOnly();
    logic [15:0] d;
    bit ok;
    int seen;
    doWrite(32, WR, PHY_A, 5'd2, 16'hFFFF, seen);
    check("R5", "write reg2 ctrlA", ctrlA, 32'h0000_1234);
    check("R5", "write reg2 ctrlB", ctrlB, 32'hBEEF_0000);
    doRead(PHY_A, 5'd2, d, ok);
    check("R5", "reg2 keeps id", {16'd0, d}, {16'd0, ID2});
    doWrite(32, WR, PHY_B, 5'd9, 16'h5555, seen);
    check("R5", "write reg9 ctrlB", ctrlB, 32'hBEEF_0000);
    doRead(PHY_B, 5'd9, d, ok);
    check("R6", "reg9 reads zero", {16'd0, d}, 32'h0);
    check("R6", "reg9 read still driven", {31'd0, ok}, 32'd1);
    doRead(PHY_A, 5'd31, d, ok);
    check("R6", "reg31 reads zero", {16'd0, d}, 32'h0);
  endtask

  task automatic testMismatch();
    logic [15:0] d;
    int seen;
    bit ok;
    doWrite(32, WR, 5'b00110, 5'd0, 16'hAAAA, seen);
    check("R2", "mismatch write ctrlA", ctrlA, 32'h0000_1234);
    check("R2", "mismatch write no drive", seen, 0);
    sendFrame(32, RD, 5'b10100, 5'd2, 16'h0, d, seen, ok);
    check("R2", "mismatch read no drive", seen, 0);
  endtask

  task automatic testPreamble();
    int seen;
    doWrite(31, WR, PHY_A, 5'd0, 16'h0F0F, seen);
    check("R1", "31-one preamble ignored", ctrlA, 32'h0000_1234);
    doWrite(32, WR, PHY_A, 5'd0, 16'h0F0F, seen);
    check("R1", "32-one preamble accepted", ctrlA, 32'h0000_0F0F);
  endtask

  task automatic testBadOpcode();
    logic [15:0] d;
    int seen;
    bit ok;
    doWrite(32, 2'b11, PHY_A, 5'd0, 16'h7777, seen);
    check("R10", "opcode 11 no write", ctrlA, 32'h0000_0F0F);
    check("R10", "opcode 11 no drive", seen, 0);
    sendFrame(32, 2'b00, PHY_B, 5'd1, 16'h7777, d, seen, ok);
    check("R10", "opcode 00 no write", ctrlB, 32'hBEEF_0000);
    check("R10", "opcode 00 no drive", seen, 0);
  endtask

  task automatic testMidReset();
    logic [15:0] d;
    bit ok;
    testReset();
    doRead(PHY_B, 5'd1, d, ok);
    check("R9", "chB reg1 after reset", {16'd0, d}, 32'h0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    testReset();
    testIdRead();
    testWrite();
    testReadOnly();
    testMismatch();
    testPreamble();
    testBadOpcode();
    testMidReset();
    finishRun();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge mdc);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule